// File: doc/BRIEF.md
# Coin Meter Latch and Player-Port Watchdog

This block sits on the CPU bus of an arcade board built around a home-console CPU and picture processor. It holds a single-bit latch that drives the coil of an electromechanical coin meter. Software turns the coil on, holds it for a few frames, and turns it off again. Each complete on-then-off cycle advances the meter by one. The latch answers to a wide mirrored address window. A read anywhere in that window also loads the latch, and the value loaded is bit 0 of whatever byte was last left on the data bus.

The same block also contains a watchdog that the game must keep fed by reading the player 1 input port. Reads of that port reset the count. If the count of clock-enable ticks reaches its limit, the watchdog issues a reset pulse of fixed length, which other logic uses to restart the CPU and picture processor. The pulse also clears the coin latch. After the pulse ends, counting starts again from zero.

A third output reports how many frames the coil has been held on, up to a saturating limit, so that the hold time can be observed.

The watchdog is a two-state machine. In `WD_RUN` it counts ticks. It takes the expiry transition to `WD_PULSE` when the last tick arrives with no port read. In `WD_PULSE` it drives the reset output, and it takes the pulse-done transition back to `WD_RUN` after `PULSE_LEN` cycles. The coil latch is also a two-state machine, `COIL_OFF` and `COIL_ON`. A load transition moves it to the state given by the loaded bit. A clear transition, taken on watchdog reset, forces it to `COIL_OFF`.

Top module: `coin_latch_wdog`

## Requirements
- R1: A write (wr_en) whose address has bits 15..13 equal to 010 and bit 5 equal to 1 loads wr_bit0 into the latch, and coil_on shows the new value from the next clock cycle.
- R2: Bus accesses whose address falls outside that window leave coil_on unchanged. Examples are 0x4000, 0x4040, 0x6020, 0x2020, and a read of 0x4017.
- R3: A read (rd_en) inside the window loads open_bus_bit0 into the latch, with the same one-cycle timing as a write.
- R4: When wr_en and rd_en are both high in the same cycle for an address in the window, the value of wr_bit0 is the one loaded.
- R5: While rst_n is low, and in the first cycle after it rises, coil_on, wd_reset and hold_frames are all 0, and the watchdog count is zero.
- R6: After TIMEOUT cycles with ce high and no read of P1_ADDR, wd_reset goes high after the clock edge of the TIMEOUT-th tick. It then stays high for exactly PULSE_LEN clock cycles.
- R7: A read (rd_en) at address P1_ADDR (0x4017 by default) resets the watchdog count to zero. Reads spaced closer than TIMEOUT ticks therefore never produce a pulse.
- R8: While ce is low, the watchdog count does not advance.
- R9: While wd_reset is high, the latch is forced to 0, writes to the window are ignored, and hold_frames then returns to 0.
- R10: When the pulse ends, the count restarts from zero, so the next pulse needs another full TIMEOUT ticks.
- R11: While coil_on is 1, hold_frames increases by one for each frame_tick and saturates at 2^HOLD_W-1. It reads 0 one cycle after coil_on is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up/system reset |
| ce | input | 1 | Clock-enable tick that paces the watchdog |
| frame_tick | input | 1 | One-cycle strobe at each video frame |
| addr | input | 16 | CPU address bus |
| wr_en | input | 1 | CPU write strobe, one cycle per access |
| rd_en | input | 1 | CPU read strobe, one cycle per access |
| wr_bit0 | input | 1 | Bit 0 of the CPU write data |
| open_bus_bit0 | input | 1 | Bit 0 of the last byte fetched on the bus |
| coil_on | output | 1 | Coin meter coil drive, high while the latch holds 1 |
| wd_reset | output | 1 | Watchdog reset pulse to CPU and picture processor |
| hold_frames | output | HOLD_W | Frames the coil has been held on, saturating |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- the latch follows the write bit or the open-bus bit after an access in the window, and keeps its value otherwise;
- a watchdog reset forces the latch off;
- a port read resets the tick count, and the count stays frozen while the enable is low;
- both counters stay within their limits;
- the hold count clears when the coil is off.

Other behaviour can only be shown by the bench scenarios: the exact expiry cycle after TIMEOUT ticks, the exact width of the pulse, the full restart after a pulse, port reads that prevent any pulse over a long run, the decoding of specific edge addresses, write-over-read priority, and saturation of the hold count.

// File: rtl/coin_wdog_pkg.sv
package coin_wdog_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic {
        COIL_OFF,
        COIL_ON
    } coil_state_t;

    typedef enum logic {
        WD_RUN,
        WD_PULSE
    } wd_state_t;

    // Window decode: top three address bits 010 and bit 5 set.
    function automatic logic in_coin_window(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:ADDR_W-3] == 3'b010) && a[5];
    endfunction

endpackage

// File: rtl/coin_coil_latch.sv
module coin_coil_latch
    import coin_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_bit,
    input  logic              ob_bit,
    output logic              coil_on
);

    coil_state_t st_q, st_d;
    logic hit_wr, hit_rd, load, load_val;

    always_comb begin
        hit_wr   = wr_en && in_coin_window(addr);
        hit_rd   = rd_en && in_coin_window(addr);
        load     = hit_wr || hit_rd;
        load_val = hit_wr ? wr_bit : ob_bit;
    end

    // next state: clear beats load, load picks the target state
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = COIL_OFF;
        end else if (load) begin
            st_d = load_val ? COIL_ON : COIL_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= COIL_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            COIL_OFF: coil_on = 1'b0;
            COIL_ON:  coil_on = 1'b1;
            default:  coil_on = 1'b0;
        endcase
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && !clr) |=> (coil_on == $past(wr_bit))); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_wr && !hit_rd && !clr) |=> $stable(coil_on)); // R2
    AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rd && !hit_wr && !clr) |=> (coil_on == $past(ob_bit))); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !coil_on); // R9

endmodule

// File: rtl/p1_watchdog.sv
module p1_watchdog
    import coin_wdog_pkg::*;
#(
    parameter int TIMEOUT   = 1789773,
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic p1_read,
    output logic wd_reset
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam int PLS_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(PULSE_LEN - 1);
    localparam logic [PLS_W-1:0] PLS_ONE  = PLS_W'(1);

    wd_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PLS_W-1:0] pcnt_q, pcnt_d;

    // next state: expiry takes RUN to PULSE, pulse-done takes PULSE to RUN
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        pcnt_d = pcnt_q;
        unique case (st_q)
            WD_RUN: begin
                if (p1_read) begin
                    cnt_d = '0;
                end else if (ce) begin
                    if (cnt_q == CNT_LAST) begin
                        st_d   = WD_PULSE;
                        cnt_d  = '0;
                        pcnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
            end
            WD_PULSE: begin
                if (pcnt_q == PLS_LAST) begin
                    st_d   = WD_RUN;
                    pcnt_d = '0;
                end else begin
                    pcnt_d = pcnt_q + PLS_ONE;
                end
            end
            default: st_d = WD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WD_RUN;
            cnt_q  <= '0;
            pcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pcnt_q <= pcnt_d;
        end
    end

    always_comb begin
        unique case (st_q)
            WD_RUN:   wd_reset = 1'b0;
            WD_PULSE: wd_reset = 1'b1;
            default:  wd_reset = 1'b0;
        endcase
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST); // R6
    AST_PULSE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= PLS_LAST); // R6
    AST_RELOAD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_RUN && p1_read) |=> (cnt_q == '0 && st_q == WD_RUN)); // R7
    AST_FROZEN_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_RUN && !ce && !p1_read) |=> ($stable(cnt_q) && st_q == WD_RUN)); // R8
    AST_RESTART_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_reset) |-> (cnt_q == '0)); // R10

endmodule

// File: rtl/coil_hold_timer.sv
module coil_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coil_on,
    input  logic              frame_tick,
    output logic [HOLD_W-1:0] hold_frames
);

    localparam logic [HOLD_W-1:0] HOLD_MAX = '1;
    localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_frames <= '0;
        end else if (!coil_on) begin
            hold_frames <= '0;
        end else if (frame_tick && hold_frames != HOLD_MAX) begin
            hold_frames <= hold_frames + HOLD_ONE;
        end
    end

    AST_HOLD_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !coil_on |=> (hold_frames == '0)); // R11
    AST_HOLD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_on && hold_frames == HOLD_MAX) |=> (hold_frames == HOLD_MAX || hold_frames == '0)); // R11

endmodule

// File: rtl/coin_latch_wdog.sv
module coin_latch_wdog
    import coin_wdog_pkg::*;
#(
    parameter int          TIMEOUT   = 1789773,
    parameter int          PULSE_LEN = 16,
    parameter int          HOLD_W    = 4,
    parameter logic [15:0] P1_ADDR   = 16'h4017
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              frame_tick,
    input  logic [15:0]       addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              wr_bit0,
    input  logic              open_bus_bit0,
    output logic              coil_on,
    output logic              wd_reset,
    output logic [HOLD_W-1:0] hold_frames
);

    logic p1_read;
    assign p1_read = rd_en && (addr == P1_ADDR);

    p1_watchdog #(
        .TIMEOUT  (TIMEOUT),
        .PULSE_LEN(PULSE_LEN)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .p1_read (p1_read),
        .wd_reset(wd_reset)
    );

    coin_coil_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wd_reset),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wr_bit (wr_bit0),
        .ob_bit (open_bus_bit0),
        .coil_on(coil_on)
    );

    coil_hold_timer #(
        .HOLD_W(HOLD_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .coil_on    (coil_on),
        .frame_tick (frame_tick),
        .hold_frames(hold_frames)
    );

endmodule

// File: tb/coin_latch_wdog_bench.sv
`timescale 1ns/1ps
module coin_latch_wdog_bench;

    localparam int TO = 40;
    localparam int PL = 4;
    localparam int HW = 4;

    logic clk = 1'b0;
    logic rst_n, ce, frame_tick, wr_en, rd_en, wr_bit0, open_bus_bit0;
    logic [15:0] addr;
    logic coil_on, wd_reset;
    logic [HW-1:0] hold_frames;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    coin_latch_wdog #(.TIMEOUT(TO), .PULSE_LEN(PL), .HOLD_W(HW)) u_coin_latch_wdog (
        .clk(clk), .rst_n(rst_n), .ce(ce), .frame_tick(frame_tick), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wr_bit0(wr_bit0), .open_bus_bit0(open_bus_bit0),
        .coil_on(coil_on), .wd_reset(wd_reset), .hold_frames(hold_frames)
    );

    // row: wr, rd, addr[15:0], wr_bit, ob_bit, expected coil
    localparam logic [20:0] VEC [14] = '{
        {1'b1, 1'b0, 16'h4020, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b0, 16'h4000, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b0, 16'h4020, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 16'h5FFF, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b0, 16'h6020, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b0, 16'h4040, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 16'h4020, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 16'h4021, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 16'h4017, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b0, 16'h4037, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 16'h4020, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b1, 16'h4020, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 16'h2020, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 16'h4020, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_bus();
        wr_en = 1'b0; rd_en = 1'b0; wr_bit0 = 1'b0; open_bus_bit0 = 1'b0; addr = 16'h0000;
    endtask

    task automatic do_reset();
        idle_bus();
        ce = 1'b0; frame_tick = 1'b0; rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    function automatic logic bench_window(input logic [15:0] a);
        return (a[15:13] == 3'b010) && (a[5] == 1'b1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timer expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        int n;
        @(negedge clk);
        do_reset();
        rst_n = 1'b0;
        check("R5 coil in reset", int'(coil_on), 0);
        check("R5 wd_reset in reset", int'(wd_reset), 0);
        check("R5 hold in reset", int'(hold_frames), 0);
        rst_n = 1'b1;
        step();
        check("R5 coil after reset", int'(coil_on), 0);

        // table walk, watchdog frozen with ce low
        for (int i = 0; i < 14; i++) begin
            wr_en = VEC[i][20]; rd_en = VEC[i][19]; addr = VEC[i][18:3];
            wr_bit0 = VEC[i][2]; open_bus_bit0 = VEC[i][1];
            step();
            if (wr_en && rd_en)             check("R4 table", int'(coil_on), int'(VEC[i][0]));
            else if (!bench_window(addr) || (!wr_en && !rd_en))
                                            check("R2 table", int'(coil_on), int'(VEC[i][0]));
            else if (rd_en)                 check("R3 table", int'(coil_on), int'(VEC[i][0]));
            else                            check("R1 table", int'(coil_on), int'(VEC[i][0]));
        end
        idle_bus();

        // hold timer counting and saturation
        wr_en = 1'b1; addr = 16'h4020; wr_bit0 = 1'b1;
        step();
        idle_bus();
        for (int k = 1; k <= 3; k++) begin
            frame_tick = 1'b1;
            step();
            frame_tick = 1'b0;
            check("R11 hold count", int'(hold_frames), k);
        end
        frame_tick = 1'b1;
        repeat (20) step();
        frame_tick = 1'b0;
        check("R11 hold saturate", int'(hold_frames), 15);
        wr_en = 1'b1; addr = 16'h4020; wr_bit0 = 1'b0;
        step();
        idle_bus();
        check("R1 coil off", int'(coil_on), 0);
        step();
        check("R11 hold cleared", int'(hold_frames), 0);

        // watchdog expiry, pulse width, latch clear
        do_reset();
        wr_en = 1'b1; addr = 16'h4020; wr_bit0 = 1'b1;
        step();
        idle_bus();
        frame_tick = 1'b1;
        step();
        frame_tick = 1'b0;
        ce = 1'b1;
        repeat (TO - 1) step();
        check("R6 no pulse before limit", int'(wd_reset), 0);
        step();
        check("R6 pulse at limit", int'(wd_reset), 1);
        n = 0;
        wr_en = 1'b1; addr = 16'h4020; wr_bit0 = 1'b1;
        while (wd_reset && n < 50) begin
            step();
            idle_bus();
            n++;
        end
        check("R6 pulse width", n, PL);
        check("R9 coil cleared by pulse", int'(coil_on), 0);
        check("R9 hold cleared by pulse", int'(hold_frames), 0);
        repeat (TO - 1) step();
        check("R10 restart no early pulse", int'(wd_reset), 0);
        step();
        check("R10 restart full window", int'(wd_reset), 1);
        repeat (PL) step();

        // port reads keep the watchdog fed
        do_reset();
        ce = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 120; i++) begin
            if (i % 30 == 29) begin rd_en = 1'b1; addr = 16'h4017; end
            else idle_bus();
            step();
            if (wd_reset) seen = 1'b1;
        end
        check("R7 fed watchdog silent", int'(seen), 0);
        rd_en = 1'b1; addr = 16'h4017;
        step();
        idle_bus();
        repeat (TO - 1) step();
        check("R7 reload then no early pulse", int'(wd_reset), 0);
        step();
        check("R7 reload then pulse", int'(wd_reset), 1);
        repeat (PL) step();

        // clock enable low freezes the count
        do_reset();
        ce = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (wd_reset) seen = 1'b1;
        end
        check("R8 frozen without ce", int'(seen), 0);
        ce = 1'b1;
        repeat (TO - 1) step();
        check("R8 count began at zero", int'(wd_reset), 0);
        step();
        check("R8 pulse after enabled ticks", int'(wd_reset), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule